// File: doc/BRIEF.md
# Segment Limit and Rights Checker

This block decides, one request at a time, whether a memory access made under legacy protected-mode segmentation must raise a general-protection fault. The requester presents the segment it addresses, the selector and cached descriptor attributes of that segment, the segment base and limit, and the access itself: the virtual address, the number of bytes, and whether it is a read, write or instruction fetch. It also presents the store-check hint, the code segment's default operand-size bit, the address-size override, and the processor's protection and 64-bit mode state.

The checker applies three tests: a null-selector test, a rights test against the readable and writable attributes, and a bounds test. The bounds test covers both the first and the last byte of the access. The offset is taken relative to the segment base and cut to 16 or 32 bits. Expand-down data segments invert the bounds test. When protection is off or the processor runs in 64-bit mode, no check applies.

A request is sampled on the clock edge where `req_valid` is high. Its verdict appears on `gp_fault` together with `rsp_valid` on the following cycle. Requests may be issued back to back on every cycle.

Top module: `seg_gp_check`

## Requirements
- R1: A request sampled with `req_valid` high yields `rsp_valid` high exactly one cycle later, carrying that request's verdict on `gp_fault`. In any cycle where `rsp_valid` is low, `gp_fault` is low, and both are low after reset. Requests may arrive on consecutive cycles.
- R2: When `prot_en` is low or `long_mode` is high, `gp_fault` is low for every request, whatever the other inputs are.
- R3: A zero selector faults for every segment index except the exempt set {7, 8, 9, 10}, where a zero selector is accepted.
- R4: For a data-class index (0 to 7), a request with `acc_mode` = 1 (write), or with `store_chk` high, faults when `attr_wr` is low. Indices 8 to 15 get no rights check.
- R5: For a data-class index (0 to 7), a request with `acc_mode` = 0 (read) faults when `attr_rd` is low. A fetch (`acc_mode` 2 or 3) is never refused on rights.
- R6: The offset is `vaddr - seg_base`, kept at 32 bits when exactly one of `cs_dflt32` and `asize_ovr` is high, and cut to its low 16 bits otherwise.
- R7: For a segment that is not expand-down, the request faults when the offset or the end offset (offset + `acc_bytes` - 1, added at 32 bits) is above `seg_limit`. A 16-bit offset of 0xFFFF with two bytes therefore reaches end offset 0x10000.
- R8: For a data-class index with `attr_expdn` high, the request faults when the offset or the end offset is at or below `seg_limit`. For indices 8 to 15, `attr_expdn` has no effect and the test of R7 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| seg_idx | input | 4 | Segment index (0-7 data class, 8-15 system/internal) |
| sel_value | input | 16 | Selector held for the segment |
| attr_rd | input | 1 | Segment readable |
| attr_wr | input | 1 | Segment writable |
| attr_expdn | input | 1 | Segment expands downward |
| seg_base | input | 32 | Segment base address |
| seg_limit | input | 32 | Segment limit |
| cs_dflt32 | input | 1 | Code segment default size is 32 bits |
| asize_ovr | input | 1 | Address-size override present |
| acc_mode | input | 2 | 0 read, 1 write, 2 or 3 fetch |
| store_chk | input | 1 | Read that must also be writable |
| prot_en | input | 1 | Protection enabled |
| long_mode | input | 1 | Processor in 64-bit mode |
| vaddr | input | 32 | Virtual address of the first byte |
| acc_bytes | input | 4 | Access size in bytes (1 to 15) |
| rsp_valid | output | 1 | Verdict present this cycle |
| gp_fault | output | 1 | General-protection fault for the request |

## Verification
The only state is the one-cycle result register, so a wrong internal value shows up on `gp_fault` in the response cycle of the very request that caused it. Nothing is held over to later requests. The bench therefore compares every response against a scoreboard entry computed from the requirements. Corner cases are placed where a wrong truncation width, an off-by-one end offset, a missed inversion for expand-down, or a wrong exempt set would flip a single verdict. Back-to-back streams expose any slip in the pairing of a request with its response.

// File: rtl/seg_gp_check.sv
module seg_gp_check #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 4,
  parameter int SEL_W       = 16,
  parameter int SIZE_W      = 4,
  parameter int NARROW_W    = 16,
  parameter int DATA_LAST   = 7,
  parameter logic [(2**IDX_W)-1:0] EXEMPT_MASK = 16'h0780
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  seg_idx,
  input  logic [SEL_W-1:0]  sel_value,
  input  logic              attr_rd,
  input  logic              attr_wr,
  input  logic              attr_expdn,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic              cs_dflt32,
  input  logic              asize_ovr,
  input  logic [1:0]        acc_mode,
  input  logic              store_chk,
  input  logic              prot_en,
  input  logic              long_mode,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [SIZE_W-1:0] acc_bytes,
  output logic              rsp_valid,
  output logic              gp_fault
);

  localparam logic [1:0] MODE_READ  = 2'd0;
  localparam logic [1:0] MODE_WRITE = 2'd1;
  localparam logic [ADDR_W-1:0] NARROW_MASK = ADDR_W'((64'd1 << NARROW_W) - 64'd1);

  logic checking, data_cls, exempt, null_flt, rights_flt, bound_flt, wide;
  logic [ADDR_W-1:0] diff, off_first, off_last;
  logic below_first, below_last, above_first, above_last;

  assign checking = prot_en & ~long_mode;
  assign data_cls = (32'(seg_idx) <= DATA_LAST);
  assign exempt   = EXEMPT_MASK[seg_idx];
  assign null_flt = (sel_value == '0) & ~exempt;

  assign rights_flt = data_cls &
                      ((~attr_wr & ((acc_mode == MODE_WRITE) | store_chk)) |
                       (~attr_rd & (acc_mode == MODE_READ)));

  assign wide      = cs_dflt32 ^ asize_ovr;
  assign diff      = vaddr - seg_base;
  assign off_first = wide ? diff : (diff & NARROW_MASK);
  assign off_last  = off_first + ADDR_W'(acc_bytes) - ADDR_W'(1);

  assign above_first = off_first > seg_limit;
  assign above_last  = off_last  > seg_limit;
  assign below_first = ~above_first;
  assign below_last  = ~above_last;

  always_comb begin
    if (data_cls && attr_expdn) bound_flt = below_first | below_last;
    else                        bound_flt = above_first | above_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      gp_fault  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      gp_fault  <= req_valid & checking & (null_flt | rights_flt | bound_flt);
    end
  end

endmodule

// File: rtl/seg_gp_check_props.sv
module seg_gp_check_props #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 4,
  parameter int SEL_W     = 16,
  parameter int DATA_LAST = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [IDX_W-1:0]  seg_idx,
  input logic [SEL_W-1:0]  sel_value,
  input logic              attr_rd,
  input logic              attr_wr,
  input logic [1:0]        acc_mode,
  input logic              store_chk,
  input logic              prot_en,
  input logic              long_mode,
  input logic              rsp_valid,
  input logic              gp_fault
);

  logic live;
  assign live = req_valid & prot_en & ~long_mode;

  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !gp_fault);

  assert_off_no_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (!prot_en || long_mode)) |=> !gp_fault);

  assert_null_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && sel_value == '0 && !(seg_idx inside {4'd7, 4'd8, 4'd9, 4'd10})) |=> gp_fault);

  assert_write_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && 32'(seg_idx) <= DATA_LAST && !attr_wr && (acc_mode == 2'd1 || store_chk)) |=> gp_fault);

  assert_read_xo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && 32'(seg_idx) <= DATA_LAST && !attr_rd && acc_mode == 2'd0) |=> gp_fault);

endmodule

bind seg_gp_check seg_gp_check_props #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEL_W(SEL_W), .DATA_LAST(DATA_LAST)
) u_props (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .seg_idx(seg_idx),
  .sel_value(sel_value), .attr_rd(attr_rd), .attr_wr(attr_wr),
  .acc_mode(acc_mode), .store_chk(store_chk), .prot_en(prot_en),
  .long_mode(long_mode), .rsp_valid(rsp_valid), .gp_fault(gp_fault)
);

// File: tb/sim_seg_gp_check.sv
module sim_seg_gp_check;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [3:0] seg_idx;
  logic [15:0] sel_value;
  logic attr_rd, attr_wr, attr_expdn, cs_dflt32, asize_ovr, store_chk, prot_en, long_mode;
  logic [31:0] seg_base, seg_limit, vaddr;
  logic [1:0] acc_mode;
  logic [3:0] acc_bytes;
  logic rsp_valid, gp_fault;

  int checks = 0, fails = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  seg_gp_check u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .seg_idx(seg_idx),
    .sel_value(sel_value), .attr_rd(attr_rd), .attr_wr(attr_wr),
    .attr_expdn(attr_expdn), .seg_base(seg_base), .seg_limit(seg_limit),
    .cs_dflt32(cs_dflt32), .asize_ovr(asize_ovr), .acc_mode(acc_mode),
    .store_chk(store_chk), .prot_en(prot_en), .long_mode(long_mode),
    .vaddr(vaddr), .acc_bytes(acc_bytes), .rsp_valid(rsp_valid), .gp_fault(gp_fault)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit model();
    logic [31:0] o, e;
    bit dc;
    if (!prot_en || long_mode) return 0;
    if (sel_value == 0 && !(seg_idx inside {4'd7, 4'd8, 4'd9, 4'd10})) return 1;
    dc = (seg_idx <= 4'd7);
    if (dc && !attr_wr && (acc_mode == 2'd1 || store_chk)) return 1;
    if (dc && !attr_rd && acc_mode == 2'd0) return 1;
    o = vaddr - seg_base;
    if (!(cs_dflt32 ^ asize_ovr)) o = o & 32'h0000FFFF;
    e = o + 32'(acc_bytes) - 32'd1;
    if (dc && attr_expdn) return (o <= seg_limit) || (e <= seg_limit);
    return (o > seg_limit) || (e > seg_limit);
  endfunction

  task automatic defaults();
    seg_idx = 4'd3; sel_value = 16'h0010; attr_rd = 1; attr_wr = 1; attr_expdn = 0;
    seg_base = 32'h0000_1000; seg_limit = 32'h0000_00FF; cs_dflt32 = 1; asize_ovr = 0;
    acc_mode = 2'd0; store_chk = 0; prot_en = 1; long_mode = 0;
    vaddr = 32'h0000_1010; acc_bytes = 4'd4;
  endtask

  // Inputs must be set by the caller before this task; it drives them at negedge.
  task automatic issue(input string tag, input bit expect_fault);
    req_valid = 1;
    exp_q.push_back(model());
    tag_q.push_back(tag);
    check(model() == expect_fault, {tag, " model"}, model(), expect_fault);
    @(negedge clk);
  endtask

  task automatic idle_check();
    req_valid = 0;
    @(negedge clk);
    @(negedge clk);
    check(rsp_valid == 0 && gp_fault == 0, "R1 idle", {rsp_valid, gp_fault}, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check(0, "R1 unexpected response", 1, 0);
      else begin
        bit ex;
        string tg;
        ex = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(gp_fault == ex, tg, gp_fault, ex);
      end
    end
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    check(rsp_valid == 0 && gp_fault == 0, "R1 reset", {rsp_valid, gp_fault}, 0);
    rst_n = 1;
    @(negedge clk);

    defaults(); issue("R7 inside", 0);
    defaults(); vaddr = 32'h0000_10FE; issue("R7 end above limit", 1);
    defaults(); vaddr = 32'h0000_10FF; acc_bytes = 1; issue("R7 at limit", 0);
    defaults(); vaddr = 32'h0000_1100; acc_bytes = 1; issue("R7 limit plus one", 1);

    defaults(); seg_base = 0; seg_limit = 32'h10; vaddr = 32'h0001_0005; cs_dflt32 = 0; asize_ovr = 0;
    issue("R6 narrow 00", 0);
    cs_dflt32 = 1; asize_ovr = 0; issue("R6 wide 10", 1);
    cs_dflt32 = 1; asize_ovr = 1; issue("R6 narrow 11", 0);
    cs_dflt32 = 0; asize_ovr = 1; issue("R6 wide 01", 1);
    defaults(); seg_base = 0; cs_dflt32 = 0; seg_limit = 32'hFFFF; vaddr = 32'h0000_FFFF; acc_bytes = 2;
    issue("R7 narrow end 0x10000", 1);
    idle_check();

    defaults(); attr_expdn = 1; seg_base = 0; seg_limit = 32'h0FFF; vaddr = 32'h2000;
    issue("R8 above limit ok", 0);
    vaddr = 32'h1000; acc_bytes = 1; issue("R8 limit plus one ok", 0);
    vaddr = 32'h0FFF; issue("R8 at limit", 1);
    vaddr = 32'h0FFE; acc_bytes = 4; issue("R8 straddle", 1);
    seg_idx = 4'd9; vaddr = 32'h2000; issue("R8 system idx ignores expdn", 1);
    vaddr = 32'h0010; issue("R8 system idx normal inside", 0);

    defaults(); sel_value = 0; issue("R3 null data", 1);
    seg_idx = 4'd8; issue("R3 null exempt 8", 0);
    seg_idx = 4'd7; issue("R3 null exempt 7", 0);
    seg_idx = 4'd10; issue("R3 null exempt 10", 0);
    seg_idx = 4'd11; issue("R3 null idx 11", 1);
    idle_check();

    defaults(); seg_idx = 2; attr_wr = 0; acc_mode = 1; issue("R4 write read-only", 1);
    acc_mode = 0; store_chk = 1; issue("R4 store-check read-only", 1);
    store_chk = 0; issue("R4 plain read read-only", 0);
    attr_wr = 1; acc_mode = 1; issue("R4 write writable", 0);
    seg_idx = 12; attr_wr = 0; issue("R4 system idx no rights", 0);

    defaults(); seg_idx = 1; attr_rd = 0; issue("R5 read unreadable", 1);
    acc_mode = 2; issue("R5 fetch unreadable", 0);
    acc_mode = 3; issue("R5 fetch alt code", 0);
    acc_mode = 1; issue("R5 write unreadable", 0);
    seg_idx = 13; acc_mode = 0; issue("R5 system idx read", 0);

    defaults(); sel_value = 0; attr_wr = 0; acc_mode = 1; vaddr = 32'h9000; prot_en = 0;
    issue("R2 protection off", 0);
    prot_en = 1; long_mode = 1; issue("R2 long mode", 0);
    long_mode = 0; issue("R2 control active", 1);
    idle_check();

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1 all responses seen", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule